// File: doc/BRIEF.md
# IR Message Match Filter and Interrupt Unit

This block sits behind an infrared symbol decoder. Every time the decoder finishes a frame, it hands over the received bits as a 64-bit message together with a length. The block captures the message. It compares the message against a programmable value/mask pair and records pending interrupt causes. The interrupt line is driven from the enabled pending causes. A second decoder path delivers its own messages, which are captured and flagged on their own. A pulse from the line-edge detector is recorded as one more interrupt cause.

A host uses one flat word-addressed register port with a synchronous write strobe and a combinational read. To get an interrupt for every frame, it enables the per-frame cause. To get interrupts only for frames it cares about, it loads the filter and enables only the match cause. Pending causes are acknowledged through a write-one-to-clear location. The capture flags in the status word are acknowledged by writing those bits as zero.

Top module: `ir_msg_filter_irq`

## Requirements
- R1: The filter value occupies addresses 0 (bits 31:0) and 1 (bits 63:32). The filter mask occupies addresses 2 (bits 31:0) and 3 (bits 63:32). Each reads back the last value written.
- R2: A path-A message is a match when every bit selected by a one in the mask equals the corresponding filter value bit. Bits with a zero in the mask do not affect the result.
- R3: When the whole 64-bit mask is zero, no message produces a match.
- R4: The pending word at address 5 and the enable word at address 4 use the same bit encoding. Bit 0 is a line edge, bit 1 is a match, bit 2 is a path-A message and bit 3 is a path-B message. Each event sets its pending bit one clock after it is presented.
- R5: A path-A message is stored at addresses 8 (bits 31:0) and 9 (bits 63:32), and its length is stored in status bits 14:8. A path-B message is stored at addresses 10 and 11.
- R6: The irq output is high exactly when some pending bit has its enable bit set.
- R7: Writing address 6 clears the pending bits written as one and leaves the other pending bits unchanged.
- R8: If an event and a clear of the same pending bit happen in the same cycle, the bit ends up set.
- R9: Status at address 7 has bit 0 as the path-A capture flag and bit 1 as the path-B capture flag. A status write clears each flag written as zero. Writing a one to a flag leaves it unchanged.
- R10: A message that arrives while its capture flag is still set overwrites the stored data, and the flag stays set. This also holds when a status write in the same cycle clears that flag.
- R11: After reset, the filter, enables, pending bits, status and captured data all read as zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Path-A message strobe, one cycle |
| msg_data | input | 64 | Path-A message bits |
| msg_len | input | 7 | Path-A message length in bits |
| msg2_valid | input | 1 | Path-B message strobe, one cycle |
| msg2_data | input | 64 | Path-B message bits |
| ir_edge | input | 1 | Line-edge event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench places mask differences in both halves of the 64-bit word and changes bits outside the mask. A comparator that split the words wrongly, or that ignored the mask, would report a wrong match bit. It sends a message with an all-zero mask and a zero filter, where a plain equality test would wrongly fire a match. It collides a clear with an event on the same pending bit, and a status acknowledge with a new message on the same cycle. A design that gave the write priority would lose a frame there. It writes ones to status and writes selective clear patterns, so a design that set flags from a write, or cleared causes it was not told to clear, would show the wrong value at the next read.

// File: rtl/ir_flt_pkg.sv
`timescale 1ns/1ps
package ir_flt_pkg;

    // Interrupt cause vector; the packing puts edge_det at bit 0.
    typedef struct packed {
        logic data2_valid;
        logic data_valid;
        logic match;
        logic edge_det;
    } irq_vec_t;

    localparam int IRQ_W = $bits(irq_vec_t);

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FDATA,
        SEL_FMASK,
        SEL_IEN,
        SEL_IPEND,
        SEL_ICLR,
        SEL_STAT,
        SEL_RXA,
        SEL_RXB
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [7:0] word;
    } reg_dec_t;

    // Address layout scales with the number of words per message.
    function automatic reg_dec_t decode_addr(input int unsigned a, input int unsigned nw);
        reg_dec_t d;
        d.sel  = SEL_NONE;
        d.word = '0;
        if (a < nw) begin
            d.sel  = SEL_FDATA;
            d.word = 8'(a);
        end else if (a < 2 * nw) begin
            d.sel  = SEL_FMASK;
            d.word = 8'(a - nw);
        end else if (a == 2 * nw) begin
            d.sel = SEL_IEN;
        end else if (a == 2 * nw + 1) begin
            d.sel = SEL_IPEND;
        end else if (a == 2 * nw + 2) begin
            d.sel = SEL_ICLR;
        end else if (a == 2 * nw + 3) begin
            d.sel = SEL_STAT;
        end else if (a < 3 * nw + 4) begin
            d.sel  = SEL_RXA;
            d.word = 8'(a - 2 * nw - 4);
        end else if (a < 4 * nw + 4) begin
            d.sel  = SEL_RXB;
            d.word = 8'(a - 3 * nw - 4);
        end
        return d;
    endfunction

    function automatic logic irq_active(input irq_vec_t p, input irq_vec_t e);
        return |(p & e);
    endfunction

endpackage

// File: rtl/ir_flt_compare.sv
`timescale 1ns/1ps
module ir_flt_compare #(
    parameter int DATA_W = 64,
    parameter int REG_W  = 32
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] flt_value,
    input  logic [DATA_W-1:0] flt_mask,
    output logic              hit
);
    localparam int NWORDS = DATA_W / REG_W;

    logic [NWORDS-1:0] word_miss;
    logic [NWORDS-1:0] word_armed;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [REG_W-1:0] diff;
        assign diff          = (data[w*REG_W +: REG_W] ^ flt_value[w*REG_W +: REG_W])
                               & flt_mask[w*REG_W +: REG_W];
        assign word_miss[w]  = |diff;
        assign word_armed[w] = |flt_mask[w*REG_W +: REG_W];
    end

    // An empty mask disarms matching entirely.
    assign hit = (|word_armed) && !(|word_miss);

endmodule

// File: rtl/ir_flt_regs.sv
`timescale 1ns/1ps
module ir_flt_regs
    import ir_flt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int REG_W  = 32,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_dec_t          dec,
    input  logic [REG_W-1:0]  wdata,
    input  logic              msg_valid,
    input  logic [DATA_W-1:0] msg_data,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              msg2_valid,
    input  logic [DATA_W-1:0] msg2_data,
    output logic [DATA_W-1:0] flt_value,
    output logic [DATA_W-1:0] flt_mask,
    output logic [DATA_W-1:0] rxa_data,
    output logic [DATA_W-1:0] rxb_data,
    output logic [LEN_W-1:0]  rxa_len,
    output logic              stat_a,
    output logic              stat_b
);
    localparam int NWORDS = DATA_W / REG_W;

    logic [REG_W-1:0] val_w  [NWORDS];
    logic [REG_W-1:0] mask_w [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_flt
        always_ff @(posedge clk) begin
            if (rst) begin
                val_w[w]  <= '0;
                mask_w[w] <= '0;
            end else if (wr_en && dec.word == 8'(w)) begin
                if (dec.sel == SEL_FDATA) val_w[w]  <= wdata;
                if (dec.sel == SEL_FMASK) mask_w[w] <= wdata;
            end
        end
        assign flt_value[w*REG_W +: REG_W] = val_w[w];
        assign flt_mask[w*REG_W +: REG_W]  = mask_w[w];
    end

    logic stat_wr;
    assign stat_wr = wr_en && (dec.sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            rxa_data <= '0;
            rxa_len  <= '0;
            rxb_data <= '0;
            stat_a   <= 1'b0;
            stat_b   <= 1'b0;
        end else begin
            if (msg_valid) begin
                rxa_data <= msg_data;
                rxa_len  <= msg_len;
            end
            if (msg2_valid) rxb_data <= msg2_data;
            // A new frame outranks a same-cycle acknowledge.
            if (msg_valid)                  stat_a <= 1'b1;
            else if (stat_wr && !wdata[0])  stat_a <= 1'b0;
            if (msg2_valid)                 stat_b <= 1'b1;
            else if (stat_wr && !wdata[1])  stat_b <= 1'b0;
        end
    end

    p_stat_set_r10: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> stat_a);

    p_stat_one_noeffect_r9: assert property (@(posedge clk) disable iff (rst)
        (!stat_a && !msg_valid) |=> !stat_a);

    p_stat2_set_r9: assert property (@(posedge clk) disable iff (rst)
        msg2_valid |=> stat_b);

endmodule

// File: rtl/ir_flt_irq.sv
`timescale 1ns/1ps
module ir_flt_irq
    import ir_flt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         ev,
    input  logic             ien_wr,
    input  logic             iclr_wr,
    input  logic [IRQ_W-1:0] wbits,
    output irq_vec_t         pend,
    output irq_vec_t         en,
    output logic             irq
);
    irq_vec_t clr_vec;

    always_comb begin
        clr_vec = '0;
        if (iclr_wr) clr_vec = irq_vec_t'(wbits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | ev;
            if (ien_wr) en <= irq_vec_t'(wbits);
        end
    end

    assign irq = irq_active(pend, en);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ev.data_valid |=> pend.data_valid);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_vec.data_valid && !ev.data_valid) |=> !pend.data_valid);

    p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en != '0));

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (!pend.edge_det && !ev.edge_det) |=> !pend.edge_det);

endmodule

// File: rtl/ir_msg_filter_irq.sv
`timescale 1ns/1ps
module ir_msg_filter_irq
    import ir_flt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int REG_W  = 32,
    parameter int LEN_W  = 7,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [DATA_W-1:0] msg_data,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              msg2_valid,
    input  logic [DATA_W-1:0] msg2_data,
    input  logic              ir_edge,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int NWORDS  = DATA_W / REG_W;
    localparam int LEN_LSB = 8;

    reg_dec_t          dec;
    logic [DATA_W-1:0] flt_value, flt_mask, rxa_data, rxb_data;
    logic [LEN_W-1:0]  rxa_len;
    logic              stat_a, stat_b, hit;
    irq_vec_t          ev, pend, en;

    always_comb dec = decode_addr(32'(reg_addr), NWORDS);

    ir_flt_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .dec        (dec),
        .wdata      (reg_wdata),
        .msg_valid  (msg_valid),
        .msg_data   (msg_data),
        .msg_len    (msg_len),
        .msg2_valid (msg2_valid),
        .msg2_data  (msg2_data),
        .flt_value  (flt_value),
        .flt_mask   (flt_mask),
        .rxa_data   (rxa_data),
        .rxb_data   (rxb_data),
        .rxa_len    (rxa_len),
        .stat_a     (stat_a),
        .stat_b     (stat_b)
    );

    ir_flt_compare #(.DATA_W(DATA_W), .REG_W(REG_W)) u_cmp (
        .data      (msg_data),
        .flt_value (flt_value),
        .flt_mask  (flt_mask),
        .hit       (hit)
    );

    always_comb begin
        ev.edge_det    = ir_edge;
        ev.match       = msg_valid && hit;
        ev.data_valid  = msg_valid;
        ev.data2_valid = msg2_valid;
    end

    ir_flt_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .ien_wr  (reg_wr && dec.sel == SEL_IEN),
        .iclr_wr (reg_wr && dec.sel == SEL_ICLR),
        .wbits   (reg_wdata[IRQ_W-1:0]),
        .pend    (pend),
        .en      (en),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (dec.sel)
            SEL_FDATA: reg_rdata = flt_value[dec.word*REG_W +: REG_W];
            SEL_FMASK: reg_rdata = flt_mask[dec.word*REG_W +: REG_W];
            SEL_RXA:   reg_rdata = rxa_data[dec.word*REG_W +: REG_W];
            SEL_RXB:   reg_rdata = rxb_data[dec.word*REG_W +: REG_W];
            SEL_IEN:   reg_rdata[IRQ_W-1:0] = en;
            SEL_IPEND: reg_rdata[IRQ_W-1:0] = pend;
            SEL_STAT: begin
                reg_rdata[0]                 = stat_a;
                reg_rdata[1]                 = stat_b;
                reg_rdata[LEN_LSB +: LEN_W]  = rxa_len;
            end
            default:   reg_rdata = '0;
        endcase
    end

    p_match_r2: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && hit) |=> pend.match);

    p_zero_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && flt_mask == '0 && !pend.match) |=> !pend.match);

    p_valid_set_r4: assert property (@(posedge clk) disable iff (rst)
        msg2_valid |=> pend.data2_valid);

endmodule

// File: tb/ir_msg_filter_irq_tb_top.sv
`timescale 1ns/1ps
module ir_msg_filter_irq_tb_top;

    localparam int NW      = 2;
    localparam int A_FD    = 0;
    localparam int A_FM    = NW;
    localparam int A_IEN   = 2 * NW;
    localparam int A_IPEND = 2 * NW + 1;
    localparam int A_ICLR  = 2 * NW + 2;
    localparam int A_STAT  = 2 * NW + 3;
    localparam int A_RXA   = 2 * NW + 4;
    localparam int A_RXB   = 3 * NW + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0, msg2_valid = 1'b0, ir_edge = 1'b0, reg_wr = 1'b0;
    logic [63:0] msg_data = '0, msg2_data = '0;
    logic [6:0]  msg_len = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    ir_msg_filter_irq dut_i (
        .clk(clk), .rst(rst),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_len(msg_len),
        .msg2_valid(msg2_valid), .msg2_data(msg2_data), .ir_edge(ir_edge),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Reference model built from the requirements.
    logic [63:0] m_fd = '0, m_fm = '0, m_rxa = '0, m_rxb = '0;
    logic [3:0]  m_en = '0, m_pend = '0;
    logic [6:0]  m_len = '0;
    logic        m_sa = 1'b0, m_sb = 1'b0;

    typedef struct {
        int          addr;
        logic [31:0] exp;
        logic        exp_irq;
        string       tag;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always @(sample_ev) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (reg_rdata !== it.exp || irq !== it.exp_irq) begin
            n_bad++;
            $display("FAIL %s: addr %0d got data %h irq %b, expected data %h irq %b",
                     it.tag, it.addr, reg_rdata, irq, it.exp, it.exp_irq);
        end
    end

    function automatic logic [31:0] model_read(input int a);
        if (a < A_FM)   return m_fd[(a - A_FD) * 32 +: 32];
        if (a < A_IEN)  return m_fm[(a - A_FM) * 32 +: 32];
        if (a == A_IEN)   return {28'b0, m_en};
        if (a == A_IPEND) return {28'b0, m_pend};
        if (a == A_STAT)  return {17'b0, m_len, 6'b0, m_sb, m_sa};
        if (a >= A_RXA && a < A_RXB)  return m_rxa[(a - A_RXA) * 32 +: 32];
        if (a >= A_RXB && a < A_RXB + NW) return m_rxb[(a - A_RXB) * 32 +: 32];
        return 32'b0;
    endfunction

    function automatic logic model_hit(input logic [63:0] d);
        return (m_fm != 64'b0) && (((d ^ m_fd) & m_fm) == 64'b0);
    endfunction

    function automatic void apply_wr(input int a, input logic [31:0] d);
        if (a < A_FM)       m_fd[(a - A_FD) * 32 +: 32] = d;
        else if (a < A_IEN) m_fm[(a - A_FM) * 32 +: 32] = d;
        else if (a == A_IEN)  m_en = d[3:0];
        else if (a == A_ICLR) m_pend = m_pend & ~d[3:0];
        else if (a == A_STAT) begin
            if (!d[0]) m_sa = 1'b0;
            if (!d[1]) m_sb = 1'b0;
        end
    endfunction

    function automatic void apply_msg(input logic [63:0] d, input logic [6:0] len);
        if (model_hit(d)) m_pend[1] = 1'b1;
        m_pend[2] = 1'b1;
        m_rxa = d;
        m_len = len;
        m_sa  = 1'b1;
    endfunction

    task automatic chk(input int a, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr   = 8'(a);
        it.addr    = a;
        it.exp     = model_read(a);
        it.exp_irq = |(m_pend & m_en);
        it.tag     = tag;
        q.push_back(it);
        #1;
        -> sample_ev;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        apply_wr(a, d);
    endtask

    task automatic send(input logic [63:0] d, input logic [6:0] len);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d; msg_len = len;
        @(negedge clk);
        msg_valid = 1'b0;
        apply_msg(d, len);
    endtask

    // Message and register write presented in the same cycle.
    task automatic send_with_wr(input logic [63:0] d, input logic [6:0] len,
                                input int a, input logic [31:0] wd);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d; msg_len = len;
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = wd;
        @(negedge clk);
        msg_valid = 1'b0; reg_wr = 1'b0;
        apply_wr(a, wd);
        apply_msg(d, len);
    endtask

    task automatic send2(input logic [63:0] d);
        @(negedge clk);
        msg2_valid = 1'b1; msg2_data = d;
        @(negedge clk);
        msg2_valid = 1'b0;
        m_rxb = d; m_sb = 1'b1; m_pend[3] = 1'b1;
    endtask

    task automatic pulse_edge();
        @(negedge clk);
        ir_edge = 1'b1;
        @(negedge clk);
        ir_edge = 1'b0;
        m_pend[0] = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        chk(A_IPEND, "R11 pending");
        chk(A_STAT,  "R11 status");
        chk(A_IEN,   "R11 enable");
        chk(A_FM + 1, "R11 mask");
        chk(A_RXA,   "R11 rx data");

        // R3: zero mask and zero filter, message of zeros must not match
        send(64'h0, 7'd32);
        chk(A_IPEND, "R3 zero mask no match / R4 valid bit");
        chk(A_STAT,  "R5 status flag and length");
        wr(A_ICLR, 32'hF);
        chk(A_IPEND, "R7 clear all");

        // R1: filter registers
        wr(A_FD,     32'h1234_5678);
        wr(A_FD + 1, 32'hA5A5_0000);
        wr(A_FM,     32'hFFFF_FFFF);
        wr(A_FM + 1, 32'hFFFF_0000);
        chk(A_FD,     "R1 value low");
        chk(A_FD + 1, "R1 value high");
        chk(A_FM,     "R1 mask low");
        chk(A_FM + 1, "R1 mask high");

        // R2: unmasked bits differ -> match
        send(64'hA5A5_BEEF_1234_5678, 7'd48);
        chk(A_IPEND, "R2 match despite unmasked diff");
        chk(A_RXA,     "R5 rx low");
        chk(A_RXA + 1, "R5 rx high");
        wr(A_ICLR, 32'h2);
        chk(A_IPEND, "R7 selective clear keeps valid");
        // R2: masked upper bit differs -> no match
        send(64'h25A5_0000_1234_5678, 7'd48);
        chk(A_IPEND, "R2 upper masked diff no match");
        // R2: masked lower bit differs -> no match
        send(64'hA5A5_0000_1234_5679, 7'd48);
        chk(A_IPEND, "R2 lower masked diff no match");

        // R6: interrupt gating
        wr(A_IEN, 32'h2);
        chk(A_IPEND, "R6 valid pending but only match enabled");
        send(64'hA5A5_0000_1234_5678, 7'd40);
        chk(A_IPEND, "R6 irq on enabled match");
        wr(A_ICLR, 32'h2);
        chk(A_IPEND, "R6 irq drops after match clear");
        wr(A_IEN, 32'h4);
        chk(A_IEN,   "R6 valid enabled irq");
        wr(A_ICLR, 32'hF);
        chk(A_IPEND, "R6 irq low after clear all");

        // R9: status acknowledge
        send2(64'hCAFE_0001_DEAD_0002);
        chk(A_STAT,    "R9 both flags set");
        chk(A_RXB,     "R5 path B low");
        chk(A_RXB + 1, "R5 path B high");
        chk(A_IPEND,   "R4 path B pending");
        wr(A_STAT, 32'h2);
        chk(A_STAT, "R9 write zero clears A only");
        wr(A_STAT, 32'h3);
        chk(A_STAT, "R9 write one no effect");

        // R10: overwrite while flag set
        send(64'h1111_2222_3333_4444, 7'd20);
        send(64'h5555_6666_7777_8888, 7'd24);
        chk(A_RXA,  "R10 overwrite low");
        chk(A_STAT, "R10 flag stays set");
        send_with_wr(64'h9999_AAAA_BBBB_CCCC, 7'd28, A_STAT, 32'h0);
        chk(A_STAT,    "R10 message beats acknowledge");
        chk(A_RXA + 1, "R10 overwrite high");

        // R8: clear colliding with event
        wr(A_ICLR, 32'hF);
        send_with_wr(64'h0, 7'd8, A_ICLR, 32'h4);
        chk(A_IPEND, "R8 set beats clear");

        // R4: edge cause
        wr(A_ICLR, 32'hF);
        wr(A_IEN, 32'h1);
        pulse_edge();
        chk(A_IPEND, "R4 edge pending and R6 irq");

        // R3: mask cleared again, matching filter value no longer fires
        wr(A_ICLR, 32'hF);
        wr(A_FM, 32'h0);
        wr(A_FM + 1, 32'h0);
        send(64'hA5A5_0000_1234_5678, 7'd48);
        chk(A_IPEND, "R3 cleared mask disables match");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule